// File: doc/BRIEF.md
# Cascaded Power-Factor-Correction Regulator

This block regulates a boost power stage so that its input current follows the shape of the rectified input voltage while the output voltage stays at a reference. It runs from a 100 MHz clock. It contains two cascaded incremental PI sections. The slow outer section compares the output voltage with the reference and produces an equivalent input conductance. The fast inner section takes, as its current target, the product of the input voltage and that conductance, compares it with the measured input current, and produces a duty count. A counter-based pulse-width modulator turns the duty count into one switch-on/off line.

All analog quantities arrive as signed fixed-point samples. Both integrators saturate at their range limits and do not wrap. A duty value that the inner loop computes during one switching period drives the switch in the following period. With the default parameters the switching period is 1000 clocks (100 kHz). The inner loop updates once per period, every 10 µs. The outer loop updates once every 1000 periods, every 10 ms.

Top module: `pfc_regulator`

## Requirements
- R1: A period counter steps from 0 to PERIOD-1 and wraps to 0. The inner loop updates on the clock edge that leaves count PERIOD-1. The outer loop updates on that same edge, but only once in every VDIV periods, starting with the VDIV-th period after reset. `cond_o` changes on no other edge.
- R2: At an outer update, the voltage error is ev = vref - vout. The integrator G, held in units of 2^-20, becomes G + 32·ev - 16·ev_prev, clamped to the range [0, 2^24-1]. Here ev_prev is the error of the previous outer update, and 0 after reset. `cond_o` equals G shifted right by 8 bits, a 16-bit value with 12 fraction bits.
- R3: The current target is (vin · cond_o) arithmetically shifted right by 12, which rounds toward minus infinity. The current error is that target minus iin.
- R4: At an inner update, the integrator D, held in units of 2^-20 counts, becomes D + 524288·ei - 507930·ei_prev, clamped to [0, PERIOD·2^20 - 1]. The newly computed D, shifted right by 20, becomes the duty count.
- R5: `duty_o` changes only on the edge where the counter wraps to 0, so a duty count holds for a whole period.
- R6: `sw_on` is high exactly while the counter value is below the duty count in effect.
- R7: The duty count always lies within 0 to PERIOD-1, so `sw_on` is low at count PERIOD-1 of every period. A large positive current error drives the duty count to PERIOD-1, and a large negative one drives it to 0.
- R8: When both loops update on the same edge, the inner loop uses the conductance from before that edge's outer update.
- R9: A synchronous reset clears both integrators, both stored errors, the counters and the duty count, so `sw_on`, `duty_o` and `cond_o` are 0 on the cycle after the reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| vin | input | DW | Signed input voltage sample |
| vout | input | DW | Signed output voltage sample |
| iin | input | DW | Signed input current sample |
| vref | input | DW | Signed output voltage reference |
| sw_on | output | 1 | Switch drive, high means switch closed |
| duty_o | output | $clog2(PERIOD) | Duty count in effect for the current period |
| cond_o | output | GW | Equivalent input conductance, GF fraction bits |

## Verification
`cond_o` and `duty_o` take new values only on the edge that leaves count PERIOD-1, one register after the inputs they sample on that edge. `sw_on` follows the counter and the duty register in the same cycle. The bench keeps a behavioural model that advances on the same rising edge and reads the same input values. The inputs change only on falling edges, and the comparison also runs on the falling edge, so every result is checked in the cycle it is due. Directed checks at the end of each phase confirm both saturation limits of the duty count, the lower clamp of the conductance and the reset values.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
    // Loop coefficients as real numbers; quantised by the top module.
    localparam real VOLT_B0 = 3.052e-5;
    localparam real VOLT_B1 = 1.526e-5;   // magnitude, applied negative
    localparam real CUR_B0  = 0.5;
    localparam real CUR_B1  = 0.4844;     // magnitude, applied negative

    typedef struct packed {
        logic cur;    // inner loop update strobe
        logic volt;   // outer loop update strobe
    } pfc_tick_t;
endpackage

// File: rtl/pfc_timebase.sv
module pfc_timebase
    import pfc_pkg::*;
#(
    parameter int PERIOD = 1000,
    parameter int VDIV   = 1000,
    localparam int DUW   = $clog2(PERIOD),
    localparam int VPW   = $clog2(VDIV + 1)
) (
    input  logic           clk,
    input  logic           rst,
    output logic [DUW-1:0] cnt,
    output pfc_tick_t      tick
);
    typedef struct packed {
        logic [DUW-1:0] cnt;
        logic [VPW-1:0] per;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      wrap;

    always_comb begin
        st_d      = st_q;
        wrap      = (st_q.cnt == DUW'(PERIOD - 1));
        tick.cur  = wrap;
        tick.volt = wrap && (st_q.per == VPW'(VDIV - 1));
        if (wrap) begin
            st_d.cnt = '0;
            st_d.per = tick.volt ? '0 : st_q.per + 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/pfc_pi_step.sv
module pfc_pi_step #(
    parameter int     EW     = 14,
    parameter int     AW     = 25,
    parameter int     CW     = 22,
    parameter int     B0     = 32,
    parameter int     B1     = -16,
    parameter longint ACC_HI = 64'd16777215,
    localparam int    SW     = AW + CW + EW + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic signed [EW-1:0] err,
    output logic signed [AW-1:0] acc_q_o,
    output logic signed [AW-1:0] acc_next_o
);
    localparam logic signed [SW-1:0] HI_S = SW'(ACC_HI);
    localparam logic signed [SW-1:0] B0_S = SW'(B0);
    localparam logic signed [SW-1:0] B1_S = SW'(B1);

    typedef struct packed {
        logic [AW-1:0] acc;
        logic [EW-1:0] eprev;
    } pi_state_t;

    pi_state_t              st_d, st_q;
    logic signed [SW-1:0]   sum;

    always_comb begin
        st_d = st_q;
        sum  = SW'($signed(st_q.acc))
             + B0_S * SW'(err)
             + B1_S * SW'($signed(st_q.eprev));
        if (en) begin
            if (sum[SW-1])        st_d.acc = '0;
            else if (sum > HI_S)  st_d.acc = AW'(ACC_HI);
            else                  st_d.acc = sum[AW-1:0];
            st_d.eprev = err;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign acc_q_o    = $signed(st_q.acc);
    assign acc_next_o = $signed(st_d.acc);
endmodule

// File: rtl/pfc_regulator.sv
module pfc_regulator
    import pfc_pkg::*;
#(
    parameter int DW     = 13,
    parameter int PERIOD = 1000,
    parameter int VDIV   = 1000,
    parameter int CF     = 20,
    parameter int GW     = 16,
    parameter int GF     = 12,
    localparam int DUW   = $clog2(PERIOD)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [DW-1:0] vin,
    input  logic signed [DW-1:0] vout,
    input  logic signed [DW-1:0] iin,
    input  logic signed [DW-1:0] vref,
    output logic                 sw_on,
    output logic [DUW-1:0]       duty_o,
    output logic [GW-1:0]        cond_o
);
    localparam int EVW = DW + 1;
    localparam int PW  = DW + GW + 1;
    localparam int EIW = PW + 1;
    localparam int AWV = GW + CF - GF + 1;
    localparam int AWI = DUW + CF + 1;
    localparam int CW  = CF + 2;
    localparam int KV0 = $rtoi(VOLT_B0 * (2.0 ** CF) + 0.5);
    localparam int KV1 = -$rtoi(VOLT_B1 * (2.0 ** CF) + 0.5);
    localparam int KI0 = $rtoi(CUR_B0 * (2.0 ** CF) + 0.5);
    localparam int KI1 = -$rtoi(CUR_B1 * (2.0 ** CF) + 0.5);
    localparam longint VACC_HI = (longint'(1) << (GW + CF - GF)) - 1;
    localparam longint IACC_HI = (longint'(PERIOD) << CF) - 1;

    typedef struct packed {
        logic [DUW-1:0] duty;
    } top_state_t;

    top_state_t             st_d, st_q;
    pfc_tick_t              tick;
    logic [DUW-1:0]         cnt_w;
    logic signed [EVW-1:0]  ev;
    logic signed [AWV-1:0]  vacc_q, vacc_next;
    logic [GW-1:0]          g;
    logic signed [PW-1:0]   prod, iref;
    logic signed [EIW-1:0]  ei;
    logic signed [AWI-1:0]  iacc_q, iacc_next;

    pfc_timebase #(.PERIOD(PERIOD), .VDIV(VDIV)) u_time (
        .clk (clk),
        .rst (rst),
        .cnt (cnt_w),
        .tick(tick)
    );

    pfc_pi_step #(.EW(EVW), .AW(AWV), .CW(CW), .B0(KV0), .B1(KV1),
                  .ACC_HI(VACC_HI)) u_vloop (
        .clk       (clk),
        .rst       (rst),
        .en        (tick.volt),
        .err       (ev),
        .acc_q_o   (vacc_q),
        .acc_next_o(vacc_next)
    );

    pfc_pi_step #(.EW(EIW), .AW(AWI), .CW(CW), .B0(KI0), .B1(KI1),
                  .ACC_HI(IACC_HI)) u_iloop (
        .clk       (clk),
        .rst       (rst),
        .en        (tick.cur),
        .err       (ei),
        .acc_q_o   (iacc_q),
        .acc_next_o(iacc_next)
    );

    always_comb begin
        st_d = st_q;
        ev   = EVW'(vref) - EVW'(vout);
        // registered conductance: a same-edge outer update is not seen yet
        g    = vacc_q[CF-GF +: GW];
        prod = PW'(vin) * $signed(PW'({1'b0, g}));
        iref = prod >>> GF;
        ei   = EIW'(iref) - EIW'(iin);
        if (tick.cur) st_d.duty = iacc_next[CF +: DUW];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign sw_on  = (cnt_w < st_q.duty);
    assign duty_o = st_q.duty;
    assign cond_o = g;
endmodule

// File: rtl/pfc_regulator_chk.sv
module pfc_regulator_chk #(
    parameter int PERIOD = 1000,
    parameter int DUW    = 10,
    parameter int GW     = 16
) (
    input logic           clk,
    input logic           rst,
    input logic [DUW-1:0] cnt,
    input logic [DUW-1:0] duty_o,
    input logic [GW-1:0]  cond_o,
    input logic           sw_on
);
    logic rst_q;

    // R7
    duty_range_chk: assert property (@(posedge clk) disable iff (rst)
        duty_o <= DUW'(PERIOD - 1));

    // R7
    last_count_off_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == DUW'(PERIOD - 1)) |-> !sw_on);

    // R5
    duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt != DUW'(PERIOD - 1)) |=> $stable(duty_o));

    // R1
    cond_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt != DUW'(PERIOD - 1)) |=> $stable(cond_o));

    always_ff @(posedge clk) begin
        if (rst_q) begin
            // R9
            reset_clear_chk: assert (!sw_on && duty_o == '0 && cond_o == '0);
        end
        rst_q <= rst;
    end
endmodule

bind pfc_regulator pfc_regulator_chk #(.PERIOD(PERIOD), .DUW(DUW), .GW(GW)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .cnt   (cnt_w),
    .duty_o(duty_o),
    .cond_o(cond_o),
    .sw_on (sw_on)
);

// File: tb/pfc_regulator_tb.sv
module pfc_regulator_tb;
    localparam int CLK_PERIOD = 10;
    localparam int P    = 20;
    localparam int V    = 3;
    localparam int DW   = 13;
    localparam int GW   = 16;
    localparam int DUW  = $clog2(P);
    localparam longint GHI = (longint'(1) << 24) - 1;
    localparam longint DHI = (longint'(P) << 20) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [DW-1:0] vin = '0, vout = '0, iin = '0, vref = '0;
    logic           sw_on;
    logic [DUW-1:0] duty_o;
    logic [GW-1:0]  cond_o;

    int checks = 0;
    int failures = 0;
    bit started = 1'b0;

    // behavioural reference state
    longint m_cnt, m_per, m_gacc, m_evp, m_dacc, m_eip, m_duty;
    longint prev_duty;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfc_regulator #(.DW(DW), .PERIOD(P), .VDIV(V), .GW(GW)) u_dut (
        .clk(clk), .rst(rst), .vin(vin), .vout(vout), .iin(iin), .vref(vref),
        .sw_on(sw_on), .duty_o(duty_o), .cond_o(cond_o)
    );

    function automatic longint clampl(longint x, longint hi);
        if (x < 0) return 0;
        if (x > hi) return hi;
        return x;
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        longint ev, g, iref, ei;
        if (rst) begin
            m_cnt = 0; m_per = 0; m_gacc = 0; m_evp = 0;
            m_dacc = 0; m_eip = 0; m_duty = 0;
        end else begin
            ev   = longint'(vref) - longint'(vout);
            g    = m_gacc >>> 8;                  // R8: conductance before update
            iref = (longint'(vin) * g) >>> 12;
            ei   = iref - longint'(iin);
            if (m_cnt == P - 1) begin
                m_dacc = clampl(m_dacc + 524288 * ei - 507930 * m_eip, DHI);
                m_eip  = ei;
                m_duty = m_dacc >>> 20;
                if (m_per == V - 1) begin
                    m_gacc = clampl(m_gacc + 32 * ev - 16 * m_evp, GHI);
                    m_evp  = ev;
                    m_per  = 0;
                end else begin
                    m_per++;
                end
                m_cnt = 0;
            end else begin
                m_cnt++;
            end
        end
    end

    always @(negedge clk) begin
        if (started) begin
            // R3 R4 R8: duty follows the cascaded loops
            chk(duty_o == DUW'(m_duty), "R4 duty", duty_o, m_duty);
            chk(cond_o == GW'(m_gacc >>> 8), "R2 cond", cond_o, m_gacc >>> 8);
            chk(sw_on == (m_cnt < m_duty), "R6 switch", sw_on, m_cnt < m_duty);
            if (!rst && m_cnt != 0)
                chk(duty_o == DUW'(prev_duty), "R5 duty held", duty_o, prev_duty);
            if (m_cnt == P - 1)
                chk(!sw_on, "R7 last count off", sw_on, 0);
            prev_duty = duty_o;
        end
    end

    task automatic periods(int n);
        repeat (n * P) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        prev_duty = 0;
        repeat (3) @(negedge clk);
        started = 1'b1;
        // R9 reset values
        chk(sw_on == 1'b0, "R9 reset sw", sw_on, 0);
        chk(duty_o == '0, "R9 reset duty", duty_o, 0);
        chk(cond_o == '0, "R9 reset cond", cond_o, 0);
        rst = 1'b0;

        // R1 R2: voltage below reference raises conductance
        vref = 13'sd3200; vout = 13'sd3000; vin = 13'sd1000; iin = 13'sd0;
        periods(40);
        chk(cond_o > 0, "R2 cond rises", cond_o, 1);

        // R7: large positive current error saturates the duty high
        iin = -13'sd2000;
        periods(10);
        chk(duty_o == DUW'(P - 1), "R7 duty high clamp", duty_o, P - 1);

        // R7: large negative current error saturates the duty low
        iin = 13'sd4000;
        periods(10);
        chk(duty_o == '0, "R7 duty low clamp", duty_o, 0);

        // R2: output above reference drives conductance down to zero
        iin = 13'sd0; vin = -13'sd1500; vout = 13'sd3600;
        periods(40);
        chk(cond_o == '0, "R2 cond low clamp", cond_o, 0);

        // mixed pattern with moderate errors
        vout = 13'sd3100; vin = 13'sd2400; iin = 13'sd20;
        periods(45);

        // R9: reset in the middle of a run
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        chk(sw_on == 1'b0, "R9 mid reset sw", sw_on, 0);
        chk(duty_o == '0, "R9 mid reset duty", duty_o, 0);
        chk(cond_o == '0, "R9 mid reset cond", cond_o, 0);
        rst = 1'b0;
        periods(12);
        finish_run();
    end
endmodule